// File: doc/BRIEF.md
# Soft-Sector Track Format Generator

This block produces the complete byte sequence needed to lay down one soft-sectored track. A host loads the cylinder number, the head number, the sector count and three gap lengths, then pulses `start_i`. The block waits for the leading edge of the next index pulse and emits the track from that point. The track opens with a leading gap. Each sector follows as a sync run, an ID address mark, four ID bytes and a checksum, then a gap, another sync run, a data address mark, the data bytes and a second checksum. After the last sector the block pads with gap fill until the index pulse returns, and then it goes idle.

The output is a byte stream with a valid/ready handshake. A side flag marks the bytes that a downstream MFM encoder must write with a missing clock bit. Each field's checksum is computed on the fly as its bytes are accepted, so the stream never has to be buffered.

Top module: `trackfmt_gen`

## Requirements
- R1: After reset, and while no format has been started, `valid_o` and `mark_o` stay low. Index pulses alone produce no bytes.
- R2: A `start_i` pulse in the idle state captures every set-up input and arms the block. The first byte is offered in the cycle after the next index leading edge is sampled (active-high by default). Set-up inputs that change after the start pulse have no effect on the track.
- R3: The track opens with `gap1_len_i` bytes of 4E. A value below 12 is raised to 12.
- R4: Sync runs are 00 bytes: 13 of them before the first ID mark of the track, and 3 before every other address mark.
- R5: An ID field is A1, FE, the cylinder high byte (cylinder zero-extended to 16 bits), the cylinder low byte, the head number as a byte, and the sector number. Sector numbers run 1, 2, … along the track.
- R6: A data field is A1, F8, then 256 bytes of E5.
- R7: Every ID field and every data field is followed by two checksum bytes, high byte first. The checksum is CRC-16 with polynomial 0x1021 (x^16+x^12+x^5+1), processed MSB first and preset to FFFF. It covers the field from its A1 byte through its last byte.
- R8: `gap2_len_i` bytes of 4E sit between each ID checksum and the following sync run. `gap3_len_i` bytes of 4E sit between the end of one sector and the next sector's sync run. A length of 0 is treated as 1.
- R9: After the last sector, or straight after the leading gap when the sector count is 0, the block emits 4E until the next index leading edge and then drops `valid_o`. Index edges that arrive earlier in the track are ignored.
- R10: `mark_o` is high exactly while the A1 byte of an address mark is on `byte_o`, and is low for every other byte.
- R11: The stream advances only on a cycle with `valid_o` and `ready_i` both high. While the consumer stalls, `byte_o` and `mark_o` hold, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arms a format run and captures the set-up inputs |
| index_i | input | 1 | Once-per-revolution index pulse |
| cyl_i | input | CYL_W | Cylinder number written into every ID field |
| head_i | input | HEAD_W | Head number written into every ID field |
| nsect_i | input | SECT_W | Sectors on the track |
| gap1_len_i | input | GAP_W | Leading gap length in bytes |
| gap2_len_i | input | GAP_W | Gap length between the ID and data fields |
| gap3_len_i | input | GAP_W | Gap length between sectors |
| byte_o | output | 8 | Current track byte |
| mark_o | output | 1 | Current byte is an address-mark A1 |
| valid_o | output | 1 | A byte is on offer |
| ready_i | input | 1 | Consumer accepts the offered byte |

## Verification
Two events can land in the same cycle: a consumer stall and a field or track boundary. One case is a stall on the first checksum byte, when the checksum register must already be frozen. The other is a stall during the closing fill at the moment the index edge ends the track. One run drives `ready_i` from a pseudo-random pattern through every field and through the closing index pulse. Its accepted stream is compared byte for byte, and flag for flag, with a reference track built from the requirements. A separate monitor reports any byte that changes while it is stalled.

// File: rtl/trackfmt_pkg.sv
`timescale 1ns/1ps
package trackfmt_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_ARMED, ST_GAP1, ST_SYNC, ST_AM1, ST_AM2,
      ST_ID, ST_DATA, ST_CRC, ST_GAP2, ST_GAP3, ST_GAP4
   } fmt_state_e;

   localparam logic [7:0] BYTE_GAP  = 8'h4E;
   localparam logic [7:0] BYTE_SYNC = 8'h00;
   localparam logic [7:0] BYTE_AM   = 8'hA1;
   localparam logic [7:0] BYTE_IDAM = 8'hFE;
   localparam logic [7:0] BYTE_DAM  = 8'hF8;
   localparam logic [15:0] CRC_POLY = 16'h1021;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;

   // One byte through the CRC, most significant bit first.
   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = r[15] ^ d[i];
         r  = {r[14:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction
endpackage

// File: rtl/trackfmt_edge.sv
`timescale 1ns/1ps
module trackfmt_edge #(
   parameter bit INDEX_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic index_i,
   output logic lead_o
);
   logic lvl, lvl_q;

   generate
      if (INDEX_ACTIVE_HIGH) begin : g_pos
         assign lvl = index_i;
      end else begin : g_neg
         assign lvl = ~index_i;
      end
   endgenerate

   // Reset to the active level so a pulse already present at reset is not taken as an edge.
   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b1;
      else        lvl_q <= lvl;
   end

   assign lead_o = lvl & ~lvl_q;
endmodule

// File: rtl/trackfmt_crc.sv
`timescale 1ns/1ps
module trackfmt_crc import trackfmt_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        en_i,
   input  logic [7:0]  din_i,
   output logic [15:0] crc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     crc_o <= CRC_SEED;
      else if (clr_i) crc_o <= CRC_SEED;
      else if (en_i)  crc_o <= crc_step(crc_o, din_i);
   end

   assert_clr_en_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_i && en_i));
endmodule

// File: rtl/trackfmt_seq.sv
`timescale 1ns/1ps
module trackfmt_seq import trackfmt_pkg::*; #(
   parameter int SECT_W     = 8,
   parameter int GAP_W      = 8,
   parameter int CNT_W      = 9,
   parameter int DATA_LEN   = 256,
   parameter int SYNC_FIRST = 13,
   parameter int SYNC_LEN   = 3,
   parameter int GAP1_MIN   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              lead_i,
   input  logic              fire_i,
   input  logic [SECT_W-1:0] nsect_i,
   input  logic [GAP_W-1:0]  gap1_i,
   input  logic [GAP_W-1:0]  gap2_i,
   input  logic [GAP_W-1:0]  gap3_i,
   output fmt_state_e        state_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [SECT_W-1:0] sec_o,
   output logic              data_phase_o,
   output logic              crc_clr_o,
   output logic              crc_en_o
);
   localparam int ID_LEN = 4;

   fmt_state_e        st, nxt;
   logic [CNT_W-1:0]  cnt, limit;
   logic [SECT_W-1:0] sec, nsect_q;
   logic [GAP_W-1:0]  g1_q, g2_q, g3_q;
   logic              dph, first, last_byte, last_sect;

   always_comb begin
      case (st)
         ST_GAP1: limit = CNT_W'(g1_q);
         ST_SYNC: limit = first ? CNT_W'(SYNC_FIRST) : CNT_W'(SYNC_LEN);
         ST_ID:   limit = CNT_W'(ID_LEN);
         ST_DATA: limit = CNT_W'(DATA_LEN);
         ST_CRC:  limit = CNT_W'(2);
         ST_GAP2: limit = CNT_W'(g2_q);
         ST_GAP3: limit = CNT_W'(g3_q);
         default: limit = CNT_W'(1);
      endcase
   end

   assign last_byte = (cnt == limit - 1'b1);
   assign last_sect = (sec == nsect_q - 1'b1);

   always_comb begin
      case (st)
         ST_GAP1: nxt = (nsect_q == '0) ? ST_GAP4 : ST_SYNC;
         ST_SYNC: nxt = ST_AM1;
         ST_AM1:  nxt = ST_AM2;
         ST_AM2:  nxt = dph ? ST_DATA : ST_ID;
         ST_ID:   nxt = ST_CRC;
         ST_DATA: nxt = ST_CRC;
         ST_CRC:  nxt = !dph ? ST_GAP2 : (last_sect ? ST_GAP4 : ST_GAP3);
         ST_GAP2: nxt = ST_SYNC;
         ST_GAP3: nxt = ST_SYNC;
         default: nxt = st;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         sec     <= '0;
         dph     <= 1'b0;
         first   <= 1'b0;
         nsect_q <= '0;
         g1_q    <= '0;
         g2_q    <= '0;
         g3_q    <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start_i) begin
               st      <= ST_ARMED;
               nsect_q <= nsect_i;
               g1_q    <= (gap1_i < GAP_W'(GAP1_MIN)) ? GAP_W'(GAP1_MIN) : gap1_i;
               g2_q    <= (gap2_i == '0) ? GAP_W'(1) : gap2_i;
               g3_q    <= (gap3_i == '0) ? GAP_W'(1) : gap3_i;
            end
            ST_ARMED: if (lead_i) begin
               st    <= ST_GAP1;
               cnt   <= '0;
               sec   <= '0;
               dph   <= 1'b0;
               first <= 1'b1;
            end
            ST_GAP4: if (lead_i) st <= ST_IDLE;
            default: if (fire_i) begin
               if (last_byte) begin
                  cnt <= '0;
                  st  <= nxt;
                  if (st == ST_SYNC) first <= 1'b0;
                  if (st == ST_GAP2) dph <= 1'b1;
                  if (st == ST_GAP3) begin
                     dph <= 1'b0;
                     sec <= sec + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign state_o      = st;
   assign cnt_o        = cnt;
   assign sec_o        = sec;
   assign data_phase_o = dph;
   assign crc_clr_o    = fire_i && (st == ST_SYNC);
   assign crc_en_o     = fire_i && (st inside {ST_AM1, ST_AM2, ST_ID, ST_DATA});

   assert_gap1_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP1 && fire_i && last_byte) |-> (cnt >= CNT_W'(GAP1_MIN - 1)));
   assert_sector_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {ST_SYNC, ST_AM1, ST_AM2, ST_ID, ST_DATA, ST_CRC, ST_GAP2, ST_GAP3})
      |-> (sec < nsect_q));
   assert_am_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AM1 && fire_i) |=> (st == ST_AM2));
endmodule

// File: rtl/trackfmt_gen.sv
`timescale 1ns/1ps
module trackfmt_gen import trackfmt_pkg::*; #(
   parameter int          CYL_W             = 10,
   parameter int          HEAD_W            = 4,
   parameter int          SECT_W            = 8,
   parameter int          GAP_W             = 8,
   parameter int          DATA_LEN          = 256,
   parameter int          SYNC_FIRST        = 13,
   parameter int          SYNC_LEN          = 3,
   parameter int          GAP1_MIN          = 12,
   parameter int          FIRST_SECT        = 1,
   parameter logic [7:0]  DATA_FILL         = 8'hE5,
   parameter bit          INDEX_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              index_i,
   input  logic [CYL_W-1:0]  cyl_i,
   input  logic [HEAD_W-1:0] head_i,
   input  logic [SECT_W-1:0] nsect_i,
   input  logic [GAP_W-1:0]  gap1_len_i,
   input  logic [GAP_W-1:0]  gap2_len_i,
   input  logic [GAP_W-1:0]  gap3_len_i,
   output logic [7:0]        byte_o,
   output logic              mark_o,
   output logic              valid_o,
   input  logic              ready_i
);
   localparam int LIM_A   = (DATA_LEN > SYNC_FIRST) ? DATA_LEN : SYNC_FIRST;
   localparam int GAP_MAX = (2 ** GAP_W) - 1;
   localparam int LIM_MAX = (LIM_A > GAP_MAX) ? LIM_A : GAP_MAX;
   localparam int CNT_W   = $clog2(LIM_MAX + 1);

   generate
      if (CYL_W < 1 || CYL_W > 16) begin : g_bad_cyl
         $error("CYL_W must be 1..16");
      end
      if (HEAD_W < 1 || HEAD_W > 8) begin : g_bad_head
         $error("HEAD_W must be 1..8");
      end
      if (SECT_W < 1 || SECT_W > 8) begin : g_bad_sect
         $error("SECT_W must be 1..8");
      end
      if (GAP1_MIN < 1 || GAP1_MIN > GAP_MAX) begin : g_bad_gap1
         $error("GAP1_MIN must fit the gap length field");
      end
      if (DATA_LEN < 1 || SYNC_FIRST < 1 || SYNC_LEN < 1) begin : g_bad_len
         $error("field lengths must be at least one byte");
      end
   endgenerate

   fmt_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [SECT_W-1:0] sec;
   logic              dph, lead, fire, crc_clr, crc_en;
   logic [15:0]       crc_q, cyl16;
   logic [CYL_W-1:0]  cyl_q;
   logic [HEAD_W-1:0] head_q;
   logic [7:0]        sect_byte, head8, byte_c;

   trackfmt_edge #(.INDEX_ACTIVE_HIGH(INDEX_ACTIVE_HIGH)) u_edge (
      .clk(clk), .rst_n(rst_n), .index_i(index_i), .lead_o(lead));

   trackfmt_seq #(
      .SECT_W(SECT_W), .GAP_W(GAP_W), .CNT_W(CNT_W), .DATA_LEN(DATA_LEN),
      .SYNC_FIRST(SYNC_FIRST), .SYNC_LEN(SYNC_LEN), .GAP1_MIN(GAP1_MIN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lead_i(lead), .fire_i(fire),
      .nsect_i(nsect_i), .gap1_i(gap1_len_i), .gap2_i(gap2_len_i), .gap3_i(gap3_len_i),
      .state_o(st), .cnt_o(cnt), .sec_o(sec), .data_phase_o(dph),
      .crc_clr_o(crc_clr), .crc_en_o(crc_en));

   trackfmt_crc u_crc (
      .clk(clk), .rst_n(rst_n), .clr_i(crc_clr), .en_i(crc_en),
      .din_i(byte_c), .crc_o(crc_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyl_q  <= '0;
         head_q <= '0;
      end else if (st == ST_IDLE && start_i) begin
         cyl_q  <= cyl_i;
         head_q <= head_i;
      end
   end

   assign cyl16     = 16'(cyl_q);
   assign head8     = 8'(head_q);
   assign sect_byte = 8'(sec) + 8'(FIRST_SECT);

   always_comb begin
      byte_c = BYTE_GAP;
      case (st)
         ST_SYNC: byte_c = BYTE_SYNC;
         ST_AM1:  byte_c = BYTE_AM;
         ST_AM2:  byte_c = dph ? BYTE_DAM : BYTE_IDAM;
         ST_ID: begin
            if      (cnt == CNT_W'(0)) byte_c = cyl16[15:8];
            else if (cnt == CNT_W'(1)) byte_c = cyl16[7:0];
            else if (cnt == CNT_W'(2)) byte_c = head8;
            else                       byte_c = sect_byte;
         end
         ST_DATA: byte_c = DATA_FILL;
         ST_CRC:  byte_c = (cnt == CNT_W'(0)) ? crc_q[15:8] : crc_q[7:0];
         default: byte_c = BYTE_GAP;
      endcase
   end

   assign byte_o  = byte_c;
   assign valid_o = !(st inside {ST_IDLE, ST_ARMED});
   assign mark_o  = (st == ST_AM1);
   assign fire    = valid_o && ready_i;

   assert_mark_a1_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |-> (valid_o && byte_o == BYTE_AM));
   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i && st != ST_GAP4) |=> (valid_o && $stable(byte_o) && $stable(mark_o)));
   assert_crc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CRC && fire && cnt == CNT_W'(0)) |=> (byte_o == $past(crc_q[7:0])));
endmodule

// File: tb/tb_trackfmt_gen.sv
`timescale 1ns/1ps
module tb_trackfmt_gen;
   typedef struct packed {
      logic [9:0] cyl;
      logic [3:0] head;
      logic [7:0] nsect;
      logic [7:0] g1;
      logic [7:0] g2;
      logic [7:0] g3;
      logic       stall;
   } cfg_t;

   localparam int NCFG = 4;
   localparam cfg_t VEC [NCFG] = '{
      '{10'h099, 4'd3, 8'd2, 8'd16, 8'd5, 8'd7, 1'b0},
      '{10'h3FF, 4'd0, 8'd1, 8'd5,  8'd1, 8'd1, 1'b0},
      '{10'h123, 4'd1, 8'd0, 8'd20, 8'd4, 8'd4, 1'b0},
      '{10'h000, 4'd2, 8'd3, 8'd12, 8'd0, 8'd0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, index_i = 1'b0, ready_i = 1'b1;
   logic [9:0] cyl_i = '0;
   logic [3:0] head_i = '0;
   logic [7:0] nsect_i = '0, gap1_len_i = '0, gap2_len_i = '0, gap3_len_i = '0;
   logic [7:0] byte_o;
   logic       mark_o, valid_o;

   always #2.5 clk = ~clk;

   trackfmt_gen dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i),
      .cyl_i(cyl_i), .head_i(head_i), .nsect_i(nsect_i),
      .gap1_len_i(gap1_len_i), .gap2_len_i(gap2_len_i), .gap3_len_i(gap3_len_i),
      .byte_o(byte_o), .mark_o(mark_o), .valid_o(valid_o), .ready_i(ready_i));

   int checks = 0, fails = 0;
   logic [7:0] exp_b [0:4095];
   logic       exp_m [0:4095];
   int         exp_t [0:4095];
   int         exp_n = 0;
   logic [7:0] got_b [0:4095];
   logic       got_m [0:4095];
   int         got_n = 0;
   int         hold_bad = 0;
   logic       prev_v = 1'b0, prev_r = 1'b0, prev_m = 1'b0;
   logic [7:0] prev_b = '0;
   logic       stall_mode = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = r[15] ^ d[i];
         r  = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   function automatic string tag_name(input int t);
      case (t)
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic push(input logic [7:0] b, input logic m, input int t);
      exp_b[exp_n] = b;
      exp_m[exp_n] = m;
      exp_t[exp_n] = t;
      exp_n++;
   endtask

   // Reference track built straight from the requirements.
   task automatic build_exp(input cfg_t c);
      int g1, g2, g3;
      logic [15:0] crc;
      logic [15:0] cyl16;
      exp_n = 0;
      g1 = (c.g1 < 12) ? 12 : int'(c.g1);
      g2 = (c.g2 == 0) ? 1 : int'(c.g2);
      g3 = (c.g3 == 0) ? 1 : int'(c.g3);
      cyl16 = {6'd0, c.cyl};
      for (int i = 0; i < g1; i++) push(8'h4E, 1'b0, 3);
      for (int s = 0; s < int'(c.nsect); s++) begin
         logic [7:0] idb [4];
         idb[0] = cyl16[15:8]; idb[1] = cyl16[7:0];
         idb[2] = {4'd0, c.head}; idb[3] = 8'(s + 1);
         for (int i = 0; i < ((s == 0) ? 13 : 3); i++) push(8'h00, 1'b0, 4);
         crc = 16'hFFFF;
         push(8'hA1, 1'b1, 5); crc = ref_crc(crc, 8'hA1);
         push(8'hFE, 1'b0, 5); crc = ref_crc(crc, 8'hFE);
         for (int i = 0; i < 4; i++) begin
            push(idb[i], 1'b0, 5);
            crc = ref_crc(crc, idb[i]);
         end
         push(crc[15:8], 1'b0, 7); push(crc[7:0], 1'b0, 7);
         for (int i = 0; i < g2; i++) push(8'h4E, 1'b0, 8);
         for (int i = 0; i < 3; i++) push(8'h00, 1'b0, 4);
         crc = 16'hFFFF;
         push(8'hA1, 1'b1, 6); crc = ref_crc(crc, 8'hA1);
         push(8'hF8, 1'b0, 6); crc = ref_crc(crc, 8'hF8);
         for (int i = 0; i < 256; i++) begin
            push(8'hE5, 1'b0, 6);
            crc = ref_crc(crc, 8'hE5);
         end
         push(crc[15:8], 1'b0, 7); push(crc[7:0], 1'b0, 7);
         if (s < int'(c.nsect) - 1)
            for (int i = 0; i < g3; i++) push(8'h4E, 1'b0, 8);
      end
   endtask

   task automatic step_cycle();
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ready_i = stall_mode ? (lfsr[1] | lfsr[4]) : 1'b1;
   endtask

   // Capture accepted bytes and watch stalled bytes, half a cycle from the active edge.
   always @(negedge clk) begin
      if (rst_n && valid_o && ready_i && got_n < 4096) begin
         got_b[got_n] = byte_o;
         got_m[got_n] = mark_o;
         got_n++;
      end
      if (rst_n && prev_v && !prev_r && valid_o && got_n < exp_n)
         if (byte_o !== prev_b || mark_o !== prev_m) hold_bad++;
      prev_v = valid_o; prev_r = ready_i; prev_b = byte_o; prev_m = mark_o;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (4) step_cycle();
      rst_n = 1'b1;
      step_cycle();
      chk(valid_o == 1'b0 && mark_o == 1'b0, "R1", "reset outputs", {valid_o, mark_o}, 0);
      index_i = 1'b1; repeat (3) step_cycle();
      index_i = 1'b0; repeat (5) step_cycle();
      chk(valid_o == 1'b0 && got_n == 0, "R1", "index without start", got_n, 0);

      for (int k = 0; k < NCFG; k++) begin
         int first_bad [16];
         bit used [16];
         int guard;
         bit mid_done, g4_ok;
         cfg_t c;
         c = VEC[k];
         build_exp(c);
         got_n = 0; hold_bad = 0; mid_done = 0;
         stall_mode = c.stall;
         cyl_i = c.cyl; head_i = c.head; nsect_i = c.nsect;
         gap1_len_i = c.g1; gap2_len_i = c.g2; gap3_len_i = c.g3;
         start_i = 1'b1; step_cycle(); start_i = 1'b0;
         // R2: inputs changed after the start pulse must not reach the track.
         cyl_i = ~c.cyl; head_i = ~c.head; nsect_i = 8'd7;
         gap1_len_i = 8'd40; gap2_len_i = 8'd9; gap3_len_i = 8'd9;
         repeat (5) step_cycle();
         chk(valid_o == 1'b0, "R2", "armed waits for index", valid_o, 0);
         index_i = 1'b1; step_cycle();
         chk(valid_o == 1'b1, "R2", "first byte after index edge", valid_o, 1);
         step_cycle(); step_cycle(); index_i = 1'b0;
         guard = 0;
         while (got_n < exp_n + 10 && guard < 30000) begin
            step_cycle();
            guard++;
            if (k == 0 && !mid_done && got_n >= 300) begin
               index_i = 1'b1; mid_done = 1;   // R9: mid-track edge ignored
            end else begin
               index_i = 1'b0;
            end
         end
         for (int t = 0; t < 16; t++) begin first_bad[t] = -1; used[t] = 0; end
         for (int i = 0; i < exp_n; i++) begin
            used[exp_t[i]] = 1; used[10] = 1;
            if (got_b[i] !== exp_b[i] && first_bad[exp_t[i]] < 0) first_bad[exp_t[i]] = i;
            if (got_m[i] !== exp_m[i] && first_bad[10] < 0) first_bad[10] = i;
         end
         for (int t = 3; t <= 10; t++) begin
            if (used[t]) begin
               if (first_bad[t] < 0)
                  chk(1'b1, tag_name(t), "field bytes", 0, 0);
               else if (t == 10)
                  chk(1'b0, tag_name(t), "mark flag", got_m[first_bad[t]], exp_m[first_bad[t]]);
               else
                  chk(1'b0, tag_name(t), "field bytes", got_b[first_bad[t]], exp_b[first_bad[t]]);
            end
         end
         g4_ok = (got_n >= exp_n + 10);
         for (int i = exp_n; i < got_n; i++)
            if (got_b[i] !== 8'h4E || got_m[i] !== 1'b0) g4_ok = 0;
         chk(g4_ok, "R9", "closing fill", got_n, exp_n + 10);
         chk(hold_bad == 0, "R11", "stalled byte held", hold_bad, 0);
         index_i = 1'b1; step_cycle(); step_cycle();
         chk(valid_o == 1'b0, "R9", "stop at closing index", valid_o, 0);
         step_cycle(); index_i = 1'b0; repeat (3) step_cycle();
      end
      stall_mode = 1'b0;
      report();
      $finish;
   end
endmodule